// File: doc/BRIEF.md
# Fractional 100 Hz Tick Divider

This block turns a 4096 Hz enable strobe into an average 100 Hz tick. It does so with a repeating fractional pattern. The ratio 40.96 is not an integer, so the divider counts 41 strobes for each of 24 ticks and then 40 strobes for one tick. That is 1024 strobes for every 25 ticks, so the tick phase is exact again every quarter second. Each tick advances a BCD hundredths counter that runs from 00 to 99. The 99-to-00 step gives a one-cycle wrap strobe, which a seconds-and-above counter can use as its increment and transfer point.

The 4096 Hz strobe is assumed to come from a 32.768 kHz source divided by eight. It arrives as a one-cycle enable in the system clock domain. The same strobe also drives a 1024 Hz square wave, which is the strobe rate divided by four. A halt control freezes all counting, standing in for a stopped oscillator. A separate control deasserts the output enable of the square wave, standing in for a high-impedance pin.

All pins are plain control and status signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure: every strobe presented while running is consumed in the cycle it arrives.

Top module: `frac_tick_divider`

## Requirements
- R1: After reset, `tick` and `hund_wrap` are 0, `hund_bcd` is 8'h00 and `sqw_out` is 0. The division pattern starts at its first long period.
- R2: Counting from reset, the first tick follows the 41st accepted strobe. Ticks 1 to 24 of every group of 25 are each 41 accepted strobes apart.
- R3: The 25th tick of each group comes 40 accepted strobes after the 24th. A whole group is therefore 1024 strobes: the 25th tick follows strobe 1024 and the 26th follows strobe 1065.
- R4: `tick` is high for exactly one clock cycle. That cycle is the one after the clock edge at which the period-completing strobe was sampled.
- R5: `hund_bcd` holds two BCD digits, tens in bits [7:4] and units in bits [3:0], each 0 to 9. It rises by one in the cycle after each tick and is otherwise stable.
- R6: `hund_wrap` is high for one cycle, in the same cycle that `hund_bcd` goes from 8'h99 to 8'h00. It is high at no other time.
- R7: While `osc_halt` is 1, strobes are ignored. `tick` stays 0 and the period counter, hundredths value and square-wave level all hold. Counting resumes from the held state once `osc_halt` returns to 0.
- R8: `sqw_out` toggles on every second accepted strobe, giving 1024 Hz for a 4096 Hz strobe. The new level appears in the cycle after that strobe.
- R9: `sqw_oe` equals the inverse of `sqw_off`, with no delay. `sqw_off` has no effect on the `sqw_out` level or on any counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_en | input | 1 | One-cycle 4096 Hz enable strobe |
| osc_halt | input | 1 | 1 stops all counting, 0 lets it run |
| sqw_off | input | 1 | 1 deasserts the square-wave output enable |
| tick | output | 1 | One-cycle 100 Hz (average) tick |
| hund_bcd | output | 8 | Hundredths of a second, two BCD digits |
| hund_wrap | output | 1 | One-cycle strobe on the 99-to-00 step |
| sqw_out | output | 1 | 1024 Hz square-wave level |
| sqw_oe | output | 1 | Output enable for the square wave |

## Verification
The square-wave divider and the period divider share one strobe. Because 41 and 40 both have mixed parity relative to the divide-by-two toggle, a period-completing strobe often toggles `sqw_out` at the same edge. The bench uses random gaps between strobes and random halted strobes to drift those alignments, and it checks the tick and the square-wave level separately after every strobe. The bench also runs the hundredths counter through several 99-to-00 wraps while strobes are being dropped by `osc_halt`. After each of these it confirms that the wrap strobe and the held value both match a model counted only from accepted strobes.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;

  localparam int unsigned DIGIT_W = 4;

  typedef logic [DIGIT_W-1:0] bcd_digit_t;

  localparam bcd_digit_t DIGIT_MAX = 4'd9;

  function automatic bcd_digit_t bcd_step(input bcd_digit_t d);
    return (d == DIGIT_MAX) ? '0 : d + 4'd1;
  endfunction

endpackage

// File: rtl/frac_period_div.sv
module frac_period_div #(
  parameter int unsigned LONG_PERIOD  = 41,
  parameter int unsigned SHORT_PERIOD = 40,
  parameter int unsigned SEQ_LEN      = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic tick_o
);
  localparam int unsigned PW = $clog2(LONG_PERIOD);
  localparam int unsigned SW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam logic [PW-1:0] LONG_LIM  = PW'(LONG_PERIOD - 1);
  localparam logic [PW-1:0] SHORT_LIM = PW'(SHORT_PERIOD - 1);
  localparam logic [SW-1:0] SEQ_LAST  = SW'(SEQ_LEN - 1);

  logic [PW-1:0] pcnt;
  logic [SW-1:0] scnt;
  logic [PW-1:0] limit;
  logic          period_done;

  // the short period closes each group of SEQ_LEN ticks
  assign limit       = (scnt == SEQ_LAST) ? SHORT_LIM : LONG_LIM;
  assign period_done = step && (pcnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt   <= '0;
      scnt   <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= period_done;
      if (period_done) begin
        pcnt <= '0;
        scnt <= (scnt == SEQ_LAST) ? '0 : scnt + 1'b1;
      end else if (step) begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcd_chain_counter.sv
module bcd_chain_counter
  import frac_tick_pkg::*;
#(
  parameter int unsigned DIGITS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inc,
  output logic [DIGITS*DIGIT_W-1:0]   value,
  output logic                        wrap
);
  logic [DIGITS:0] carry;
  bcd_digit_t      dig [DIGITS];

  assign carry[0] = inc;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    assign carry[d+1] = carry[d] && (dig[d] == DIGIT_MAX);
    assign value[d*DIGIT_W +: DIGIT_W] = dig[d];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dig[d] <= '0;
      end else if (carry[d]) begin
        dig[d] <= bcd_step(dig[d]);
      end
    end
  end

  // carry out of the top digit is the all-nines to all-zeros step
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrap <= 1'b0;
    end else begin
      wrap <= carry[DIGITS];
    end
  end
endmodule

// File: rtl/sqw_divider.sv
module sqw_divider #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic level
);
  localparam int unsigned HALF = DIV / 2;

  if (HALF <= 1) begin : g_direct
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        level <= 1'b0;
      end else if (step) begin
        level <= ~level;
      end
    end
  end else begin : g_counted
    localparam int unsigned CW = $clog2(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt   <= '0;
        level <= 1'b0;
      end else if (step) begin
        if (cnt == LAST) begin
          cnt   <= '0;
          level <= ~level;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frac_tick_divider.sv
module frac_tick_divider
  import frac_tick_pkg::*;
#(
  parameter int unsigned LONG_PERIOD  = 41,
  parameter int unsigned SHORT_PERIOD = 40,
  parameter int unsigned SEQ_LEN      = 25,
  parameter int unsigned HUND_DIGITS  = 2,
  parameter int unsigned SQW_DIV      = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              base_en,
  input  logic                              osc_halt,
  input  logic                              sqw_off,
  output logic                              tick,
  output logic [HUND_DIGITS*DIGIT_W-1:0]    hund_bcd,
  output logic                              hund_wrap,
  output logic                              sqw_out,
  output logic                              sqw_oe
);
  logic run_step;

  // a halted oscillator swallows every strobe
  assign run_step = base_en && !osc_halt;
  assign sqw_oe   = !sqw_off;

  frac_period_div #(
    .LONG_PERIOD (LONG_PERIOD),
    .SHORT_PERIOD(SHORT_PERIOD),
    .SEQ_LEN     (SEQ_LEN)
  ) u_period (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (run_step),
    .tick_o(tick)
  );

  bcd_chain_counter #(
    .DIGITS(HUND_DIGITS)
  ) u_hund (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (tick),
    .value(hund_bcd),
    .wrap (hund_wrap)
  );

  sqw_divider #(
    .DIV(SQW_DIV)
  ) u_sqw (
    .clk  (clk),
    .rst_n(rst_n),
    .step (run_step),
    .level(sqw_out)
  );
endmodule

// File: rtl/frac_tick_checker.sv
module frac_tick_checker #(
  parameter int unsigned LONG_PERIOD  = 41,
  parameter int unsigned SHORT_PERIOD = 40,
  parameter int unsigned DIGITS       = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  base_en,
  input logic                  osc_halt,
  input logic                  tick,
  input logic [DIGITS*4-1:0]   hund_bcd,
  input logic                  hund_wrap,
  input logic                  sqw_out
);
  localparam logic [DIGITS*4-1:0] ALL_NINES = {DIGITS{4'h9}};

  logic [15:0] gap_cnt;
  logic        accepted;

  assign accepted = base_en && !osc_halt;

  // accepted strobes since the last tick, including the closing one
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= '0;
    end else if (tick) begin
      gap_cnt <= accepted ? 16'd1 : 16'd0;
    end else if (accepted) begin
      gap_cnt <= gap_cnt + 16'd1;
    end
  end

  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_cnt == 16'(LONG_PERIOD) || gap_cnt == 16'(SHORT_PERIOD)));

  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_tick_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(base_en));

  assert_hund_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(hund_bcd));

  assert_hund_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick) |-> !$stable(hund_bcd));

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit_chk
    assert_digit_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hund_bcd[d*4 +: 4] <= 4'd9);
  end

  assert_wrap_point_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hund_wrap |-> (hund_bcd == '0) && ($past(hund_bcd) == ALL_NINES));

  assert_halt_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !$past(osc_halt));

  assert_halt_sqw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    osc_halt |=> $stable(sqw_out));

  assert_sqw_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sqw_out != $past(sqw_out)) |-> $past(base_en && !osc_halt));
endmodule

bind frac_tick_divider frac_tick_checker #(
  .LONG_PERIOD (LONG_PERIOD),
  .SHORT_PERIOD(SHORT_PERIOD),
  .DIGITS      (HUND_DIGITS)
) i_frac_tick_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .base_en  (base_en),
  .osc_halt (osc_halt),
  .tick     (tick),
  .hund_bcd (hund_bcd),
  .hund_wrap(hund_wrap),
  .sqw_out  (sqw_out)
);

// File: tb/test_frac_tick_divider.sv
`timescale 1ns/1ps
module test_frac_tick_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_en = 1'b0;
  logic       osc_halt = 1'b0;
  logic       sqw_off = 1'b0;
  logic       tick;
  logic [7:0] hund_bcd;
  logic       hund_wrap;
  logic       sqw_out;
  logic       sqw_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  int m_pcnt = 0, m_seq = 0, m_hund = 0, m_sqc = 0, m_sqw = 0;
  int accepted = 0, tick_no = 0;
  int first_tick_at = -1, tick25_at = -1, tick26_at = -1;

  always #10 clk = ~clk;

  frac_tick_divider i_frac_tick_divider (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_en  (base_en),
    .osc_halt (osc_halt),
    .sqw_off  (sqw_off),
    .tick     (tick),
    .hund_bcd (hund_bcd),
    .hund_wrap(hund_wrap),
    .sqw_out  (sqw_out),
    .sqw_oe   (sqw_oe)
  );

  function automatic int to_bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int period_of(input int seq);
    return (seq == 24) ? 40 : 41;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe(input bit halt, input int gap);
    int exp_tick;
    int exp_wrap;
    int prev_hund;
    @(negedge clk);
    base_en  = 1'b1;
    osc_halt = halt;
    sqw_off  = 1'($urandom_range(0, 1));
    exp_tick = 0;
    if (!halt) begin
      accepted++;
      m_pcnt++;
      if (m_pcnt == period_of(m_seq)) begin
        exp_tick = 1;
        m_pcnt = 0;
        m_seq = (m_seq + 1) % 25;
        tick_no++;
        if (tick_no == 1)  first_tick_at = accepted;
        if (tick_no == 25) tick25_at = accepted;
        if (tick_no == 26) tick26_at = accepted;
      end
      m_sqc++;
      if (m_sqc == 2) begin
        m_sqc = 0;
        m_sqw ^= 1;
      end
    end
    @(negedge clk);
    base_en  = 1'b0;
    check(halt ? "R7 tick while halted" : "R4 tick after strobe", int'(tick), exp_tick);
    check(halt ? "R7 sqw held" : "R8 sqw level", int'(sqw_out), m_sqw);
    check("R9 sqw_oe", int'(sqw_oe), int'(!sqw_off));
    check(halt ? "R7 hund held" : "R5 hund before step", int'(hund_bcd), to_bcd(m_hund));
    osc_halt = 1'($urandom_range(0, 1));
    prev_hund = m_hund;
    exp_wrap = 0;
    if (exp_tick == 1) begin
      exp_wrap = (prev_hund == 99) ? 1 : 0;
      m_hund = (m_hund + 1) % 100;
    end
    @(negedge clk);
    check("R4 tick one cycle", int'(tick), 0);
    check("R5 hund value", int'(hund_bcd), to_bcd(m_hund));
    check("R6 wrap strobe", int'(hund_wrap), exp_wrap);
    for (int g = 0; g < gap; g++) @(negedge clk);
    osc_halt = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4096));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 tick", int'(tick), 0);
    check("R1 hund", int'(hund_bcd), 0);
    check("R1 wrap", int'(hund_wrap), 0);
    check("R1 sqw", int'(sqw_out), 0);
    // directed: run a clean group with no halts and minimal gaps
    for (int i = 0; i < 1100; i++) strobe(1'b0, 0);
    check("R2 first tick strobe", first_tick_at, 41);
    check("R3 tick 25 strobe", tick25_at, 1024);
    check("R3 tick 26 strobe", tick26_at, 1065);
    // directed: a long halted stretch holds everything
    for (int i = 0; i < 60; i++) strobe(1'b1, 1);
    // random mix: gaps, halts, and several hundredths wraps
    for (int i = 0; i < 9000; i++) begin
      strobe(($urandom_range(0, 9) == 0), $urandom_range(0, 2));
    end
    check("R6 wraps reached", int'(tick_no >= 200), 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule